// File: doc/BRIEF.md
# Four-Level Pulse Envelope Generator

This block produces the per-slice enable waveforms that shape each transmitted pulse into a stepped amplitude envelope with four levels. Time runs on a fine tick grid: one pulse period is split into twenty ticks of the tick clock. A free-running tick counter yields four duty-cycled phases whose falling edges sit at ticks 4, 8, 12 and 16. Two pairs of phases are combined by XOR into a wide window and a narrow window. Each window also goes through a programmable delay tap, which gives four shaping signals in all.

Sixty driver slices, in two groups of thirty, each pick one of the four shaping signals or a constant off through a 3-bit source select. How many slices share a shaping signal sets that signal's weight in the envelope. The block also reports the number of enabled slices as a digital amplitude, updated every tick. When the pulse-active flag is low, every slice is held off and the tick grid restarts.

Top module: `pulse_envelope_gen`

## Requirements
- R1: While reset is asserted, all 60 slice enables and the amplitude output read zero.
- R2: With run_i held high, the outputs change on the clock edge that samples the inputs. The edge n counted from the first edge with run_i high (n = 0, 1, ...) presents tick n mod 20.
- R3: Shaping signal S1 is the XOR of the 20% and 80% duty phases. It is high on ticks 4 to 15 of each period.
- R4: Shaping signal S3 is the XOR of the 40% and 60% duty phases. It is high on ticks 8 to 11 of each period.
- R5: S2 is S1 delayed by dly_wide_i ticks, and S4 is S3 delayed by dly_narrow_i ticks. Each delay is 0 to 3 ticks, and a delayed signal reads zero for ticks before the pulse started.
- R6: Slice i takes its select from sel_i[3*i+2:3*i]. Code 1 picks S1, 2 picks S2, 3 picks S3 and 4 picks S4. Codes 0, 5, 6 and 7 hold the slice off.
- R7: amp_o always equals the number of set bits in slice_en_o, in the range 0 to 60.
- R8: On a clock edge where run_i is low, every enable and the amplitude drop to zero. The next edge with run_i high restarts at tick 0 with cleared delay history.
- R9: The amplitude is zero on ticks 19 and 0 to 3 of every period, for every delay setting.
- R10: Peak amplitude, with every mapped slice on, occurs only on ticks where all four shaping signals are high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twenty ticks per pulse period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Pulse-active flag |
| dly_wide_i | input | 2 | Delay in ticks from S1 to S2 |
| dly_narrow_i | input | 2 | Delay in ticks from S3 to S4 |
| sel_i | input | 180 | Source select, 3 bits per slice |
| slice_en_o | output | 60 | Registered slice enables |
| amp_o | output | 6 | Number of enabled slices |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. The enables and the amplitude are registered once after the tick counter, the delay taps and the routing, so the tick presented at edge n depends only on run_i, the delays and the select map sampled at that edge. The driver sets inputs on the falling edge and pushes the expected enables for the next rising edge. The monitor pops that item five nanoseconds after the rising edge, so each comparison lands on the first edge where the value is valid. Before comparing, a stop in mid-period is followed by a restart from tick zero in the reference model.

// File: rtl/pulse_envelope_pkg.sv
`timescale 1ns/1ps
package pulse_envelope_pkg;
    localparam int TICKS   = 20;
    localparam int PHASES  = 4;
    localparam int EDGE    = TICKS / (PHASES + 1);
    localparam int SLICES  = 60;
    localparam int SEL_W   = 3;
    localparam int DLY_W   = 2;
    localparam int MAXD    = (1 << DLY_W) - 1;
    localparam int TICK_W  = $clog2(TICKS);
    localparam int AMP_W   = $clog2(SLICES + 1);
    localparam int NSHAPE  = 4;

    typedef struct packed {
        logic [SLICES-1:0] en;
        logic [AMP_W-1:0]  amp;
    } drive_state_t;
endpackage

// File: rtl/phase_ticker.sv
`timescale 1ns/1ps
module phase_ticker
    import pulse_envelope_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    output logic [TICK_W-1:0] tick_o,
    output logic              wide_o,
    output logic              narrow_o
);
    localparam logic [TICK_W-1:0] LAST = TICK_W'(TICKS - 1);

    logic [TICK_W-1:0] cnt_d, cnt_q;
    logic [PHASES-1:0] ph;

    always_comb begin
        cnt_d = '0;
        if (run_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // phase k is high for the first (k+1)*EDGE ticks of a period
    for (genvar k = 0; k < PHASES; k++) begin : g_phase
        assign ph[k] = (cnt_q < TICK_W'(EDGE * (k + 1)));
    end

    assign wide_o   = ph[0] ^ ph[PHASES-1];
    assign narrow_o = ph[1] ^ ph[PHASES-2];
    assign tick_o   = cnt_q;
endmodule

// File: rtl/tap_delay.sv
`timescale 1ns/1ps
module tap_delay
    import pulse_envelope_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             bit_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             bit_o
);
    // hist_q[j] holds bit_i as it was j+1 ticks ago
    logic [MAXD-1:0]  hist_d, hist_q;
    logic [DLY_W-1:0] idx;

    always_comb begin
        hist_d = run_i ? {hist_q[MAXD-2:0], bit_i} : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= hist_d;
    end

    assign idx   = dly_i - 1'b1;
    assign bit_o = (dly_i == '0) ? bit_i : hist_q[idx];
endmodule

// File: rtl/slice_router.sv
`timescale 1ns/1ps
module slice_router
    import pulse_envelope_pkg::*;
(
    input  logic [NSHAPE-1:0]       shape_i,
    input  logic [SLICES*SEL_W-1:0] sel_i,
    output logic [SLICES-1:0]       en_o
);
    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        logic [SEL_W-1:0] code;
        assign code = sel_i[i*SEL_W +: SEL_W];
        always_comb begin
            unique case (code)
                3'd1:    en_o[i] = shape_i[0];
                3'd2:    en_o[i] = shape_i[1];
                3'd3:    en_o[i] = shape_i[2];
                3'd4:    en_o[i] = shape_i[3];
                default: en_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pulse_envelope_gen.sv
`timescale 1ns/1ps
module pulse_envelope_gen
    import pulse_envelope_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    run_i,
    input  logic [DLY_W-1:0]        dly_wide_i,
    input  logic [DLY_W-1:0]        dly_narrow_i,
    input  logic [SLICES*SEL_W-1:0] sel_i,
    output logic [SLICES-1:0]       slice_en_o,
    output logic [AMP_W-1:0]        amp_o
);
    logic [TICK_W-1:0] tick_w;
    logic              wide_w, narrow_w;
    logic [NSHAPE-1:0] shape_w;
    logic [SLICES-1:0] route_w;
    drive_state_t      st_d, st_q;

    phase_ticker u_ticker (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .tick_o   (tick_w),
        .wide_o   (wide_w),
        .narrow_o (narrow_w)
    );

    assign shape_w[0] = wide_w;
    assign shape_w[2] = narrow_w;

    tap_delay u_tap_wide (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_i),
        .bit_i  (wide_w),
        .dly_i  (dly_wide_i),
        .bit_o  (shape_w[1])
    );

    tap_delay u_tap_narrow (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_i),
        .bit_i  (narrow_w),
        .dly_i  (dly_narrow_i),
        .bit_o  (shape_w[3])
    );

    slice_router u_router (
        .shape_i (shape_w),
        .sel_i   (sel_i),
        .en_o    (route_w)
    );

    always_comb begin
        st_d     = '0;
        st_d.en  = run_i ? route_w : '0;
        for (int i = 0; i < SLICES; i++) begin
            st_d.amp = st_d.amp + {{(AMP_W-1){1'b0}}, st_d.en[i]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign slice_en_o = st_q.en;
    assign amp_o      = st_q.amp;
endmodule

// File: rtl/pulse_envelope_chk.sv
`timescale 1ns/1ps
module pulse_envelope_chk
    import pulse_envelope_pkg::*;
(
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    run_i,
    input logic [SLICES*SEL_W-1:0] sel_i,
    input logic [SLICES-1:0]       slice_en_o,
    input logic [AMP_W-1:0]        amp_o,
    input logic [TICK_W-1:0]       tick_w
);
    logic [SLICES-1:0] off_mask;
    for (genvar i = 0; i < SLICES; i++) begin : g_off
        assign off_mask[i] = (sel_i[i*SEL_W +: SEL_W] == 3'd0) ||
                             (sel_i[i*SEL_W +: SEL_W] > 3'd4);
    end

    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |=> (slice_en_o == '0 && amp_o == '0));

    a_r2_tick_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_w < TICK_W'(TICKS));

    a_r6_static_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |=> ((slice_en_o & $past(off_mask)) == '0));

    a_r7_amp_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        amp_o == AMP_W'($countones(slice_en_o)));

    a_r8_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (slice_en_o == '0 && amp_o == '0));

    a_r9_edge_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && (tick_w >= TICK_W'(TICKS - 1) || tick_w < TICK_W'(EDGE)))
        |=> (amp_o == '0));
endmodule

bind pulse_envelope_gen pulse_envelope_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .sel_i      (sel_i),
    .slice_en_o (slice_en_o),
    .amp_o      (amp_o),
    .tick_w     (tick_w)
);

// File: tb/pulse_envelope_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_envelope_gen_tb_top;
    import pulse_envelope_pkg::*;

    typedef struct {
        logic [SLICES-1:0] en;
        int                amp;
        string             tag;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    run = 1'b0;
    logic [DLY_W-1:0]        dly_a = '0;
    logic [DLY_W-1:0]        dly_b = '0;
    logic [SLICES*SEL_W-1:0] sel = '0;
    logic [SLICES-1:0]       slice_en;
    logic [AMP_W-1:0]        amp;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   reported = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    pulse_envelope_gen dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .run_i        (run),
        .dly_wide_i   (dly_a),
        .dly_narrow_i (dly_b),
        .sel_i        (sel),
        .slice_en_o   (slice_en),
        .amp_o        (amp)
    );

    function automatic bit wide_at(int n);
        if (n < 0) return 1'b0;
        return ((n % TICKS) >= 4) && ((n % TICKS) < 16);
    endfunction

    function automatic bit narrow_at(int n);
        if (n < 0) return 1'b0;
        return ((n % TICKS) >= 8) && ((n % TICKS) < 12);
    endfunction

    function automatic logic [SLICES-1:0] model(logic [SLICES*SEL_W-1:0] m,
                                                int n, int da, int db);
        logic [SLICES-1:0] r;
        bit s[1:4];
        s[1] = wide_at(n);
        s[2] = wide_at(n - da);
        s[3] = narrow_at(n);
        s[4] = narrow_at(n - db);
        for (int i = 0; i < SLICES; i++) begin
            int c;
            c = int'(m[i*SEL_W +: SEL_W]);
            r[i] = (c >= 1 && c <= 4) ? s[c] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic [SLICES*SEL_W-1:0] mk_map(int kind);
        logic [SLICES*SEL_W-1:0] m;
        for (int i = 0; i < SLICES; i++) begin
            int c;
            case (kind)
                0:       c = 1;
                1:       c = 3;
                2:       c = i % 5;
                3:       c = 1 + (i % 4);
                default: c = (i < 30) ? 5 + (i % 3) : 2;
            endcase
            m[i*SEL_W +: SEL_W] = 3'(c);
        end
        return m;
    endfunction

    task automatic push(logic [SLICES-1:0] e, string tag);
        exp_t it;
        it.en  = e;
        it.amp = $countones(e);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic burst(int kind, int da, int db, int cycles, string tag);
        logic [SLICES*SEL_W-1:0] m;
        m = mk_map(kind);
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            run   = 1'b1;
            sel   = m;
            dly_a = DLY_W'(da);
            dly_b = DLY_W'(db);
            push(model(m, n, da, db), tag);
        end
    endtask

    task automatic idle(int cycles);
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            run = 1'b0;
            push('0, "R8");
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // monitor: compares each output one clock after its inputs were driven
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_tests++;
                if (slice_en !== it.en) begin
                    n_fail++;
                    $display("FAIL %s enables got %h exp %h", it.tag, slice_en, it.en);
                end
                n_tests++;
                if (int'(amp) != it.amp) begin
                    n_fail++;
                    $display("FAIL R7 amplitude got %0d exp %0d", amp, it.amp);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired, queue %0d exp 0", q.size());
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        n_tests++;
        if (slice_en !== '0 || amp !== '0) begin
            n_fail++;
            $display("FAIL R1 reset en %h amp %0d exp 0", slice_en, amp);
        end
        @(negedge clk);
        rst_n = 1'b1;
        burst(0, 0, 0, 20, "R3");           // S1 on ticks 4..15
        idle(1);
        burst(1, 0, 0, 20, "R4");           // S3 on ticks 8..11
        idle(1);
        burst(2, 2, 1, 40, "R5");           // weighted mix with delays
        idle(1);
        burst(3, 0, 0, 20, "R10");          // 60 only while all four high
        idle(1);
        burst(4, 3, 3, 25, "R6");           // codes 5..7 stay off
        idle(1);
        burst(3, 3, 3, 40, "R9");           // max delays keep edges quiet
        burst(2, 1, 2, 10, "R2");           // continues, then stop mid-period
        idle(3);
        burst(3, 1, 2, 25, "R8");           // restart from tick 0
        idle(2);
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        #6;
        report();
    end
endmodule